// File: doc/BRIEF.md
# Completion Ring Poller with Pass-Count Ownership

This block drains a ring of fixed-size completion records that another agent writes into memory. It keeps a local head index into the ring and never learns where the producer's write point is. Instead it reads the control word of the record at the head and compares that word's 3-bit pass field with the pass the head is currently on. A match means the record is fresh. A value one pass behind means the ring is drained. Any other value means the producer has lapped the consumer.

A poll request names the largest number of records to drain and whether to arm the queue afterwards. For each fresh record the block streams out the work-queue number, the send/receive flag and the fifteen payload words, and it advances the head by one. When the poll ends it pulses a done strobe carrying the number of records returned and an overflow flag. If arming was asked for, it then writes a 64-bit doorbell word. That word carries the queue id, the final head and a set arm bit, so the next record can raise an event.

Top module: `cq_poller`

## Requirements
- R1: After reset the head is zero, and `poll_done`, `cmp_valid` and `db_valid` are low. Owner 0 is the pass expected first.
- R2: Each record is 16 words of 32 bits at word address `{slot, word}`. Words 0..14 are payload and word 15 is the control word. In the control word, bits [23:0] are the work-queue number, bit 24 is the send flag and bits [31:29] are the owner. Bits [28:25] have no effect.
- R3: The expected owner is `(head >> LOG2_ENTRIES) & 7`. A record whose owner matches is emitted with payload word i on `cmp_data[32*i +: 32]`.
- R4: A record whose owner equals the expected owner minus one (mod 8) ends the poll as empty, and it is neither emitted nor consumed.
- R5: Any other owner value ends the poll with `poll_overflow` set. The head does not move and nothing is emitted for that record.
- R6: A poll emits at most `poll_max` records. When `poll_max` is 0, the poll ends with a count of 0 and reads nothing.
- R7: The head advances by exactly one per emitted record and wraps through the ring. After the wrap, the expected owner becomes the next pass.
- R8: `poll_done` pulses for one cycle, and `poll_count` then equals the number of records emitted by that poll.
- R9: With `poll_arm` set, `db_valid` pulses in the cycle after `poll_done`, carrying `{1'b1, head[30:0], 8'h00, cq_id}`. With `poll_arm` clear, no doorbell is written.
- R10: A `poll_req` that arrives while a poll is in progress is ignored.
- R11: On an empty ring, `poll_done` rises two cycles after the cycle in which the request is seen. Each emitted record takes 19 cycles, and its `cmp_valid` appears 18 cycles after the request for the first record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cq_id | input | 24 | Queue id placed in the doorbell |
| poll_req | input | 1 | Start a poll (taken only when idle) |
| poll_max | input | CNT_W | Largest number of records to drain |
| poll_arm | input | 1 | Write an armed doorbell after the poll |
| poll_done | output | 1 | One-cycle end-of-poll strobe |
| poll_count | output | CNT_W | Records emitted by the poll, valid with `poll_done` |
| poll_overflow | output | 1 | Producer lapped the consumer, valid with `poll_done` |
| mem_rd_en | output | 1 | Ring read strobe |
| mem_rd_addr | output | LOG2_ENTRIES+4 | Ring word address |
| mem_rd_data | input | 32 | Read data, one cycle after `mem_rd_en` |
| cmp_valid | output | 1 | One-cycle strobe for a decoded record |
| cmp_wq_num | output | 24 | Work-queue number |
| cmp_is_sq | output | 1 | Send-queue flag |
| cmp_data | output | 480 | Payload words 0..14 |
| db_valid | output | 1 | Doorbell write strobe |
| db_word | output | 64 | Doorbell word |

## Verification
The bench keeps a falling-edge cycle stamp for the request, each completion strobe, the done strobe and the doorbell strobe. It then checks the distances between these stamps against the latencies in R11 and R9. On an empty ring, done must come exactly two stamps after the request. The first record must be emitted eighteen stamps after the request. The doorbell must come exactly one stamp after done. Counts, fields and payload are compared against the record images the bench wrote into its memory model. The head is followed in the bench and observed through the doorbell pointer.

// File: rtl/cq_pkg.sv
// Shared constants and types for the completion ring poller.
// Assumes 32-bit memory words and 16-word records.
package cq_pkg;
    localparam int WORD_W       = 32;
    localparam int REC_WORDS    = 16;
    localparam int WIDX_W       = $clog2(REC_WORDS);
    localparam int PAY_WORDS    = REC_WORDS - 1;
    localparam int PAY_W        = PAY_WORDS * WORD_W;
    localparam int CTRL_IDX     = REC_WORDS - 1;
    localparam int WQ_W         = 24;
    localparam int OWNER_W      = 3;
    localparam int PTR_W        = 31;
    localparam int DB_RSV_W     = 8;
    localparam int DB_W         = 1 + PTR_W + DB_RSV_W + WQ_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CTRL,
        ST_WAIT_CTRL,
        ST_RD_PAY,
        ST_PAY_LAST,
        ST_EMIT,
        ST_DONE
    } poll_state_e;

    typedef enum logic [1:0] {
        OWN_NEW,
        OWN_EMPTY,
        OWN_BAD
    } owner_cls_e;
endpackage

// File: rtl/cq_owner_classify.sv
// Classifies a record's owner field against the pass the head is on.
// Assumes the ring holds 2**LOG2_ENTRIES records and LOG2_ENTRIES+3 <= PTR_W.
module cq_owner_classify
    import cq_pkg::*;
#(
    parameter int LOG2_ENTRIES = 4
) (
    input  logic [PTR_W-1:0]   head,
    input  logic [OWNER_W-1:0] owner,
    output owner_cls_e         cls
);
    logic [OWNER_W-1:0] expect_own;
    logic [OWNER_W-1:0] behind_own;

    // Derive the current pass and the pass before it.
    always_comb begin
        expect_own = head[LOG2_ENTRIES +: OWNER_W];
        behind_own = expect_own - OWNER_W'(1);
    end

    // Map the owner value onto fresh, drained or lapped.
    always_comb begin
        if (owner == expect_own)      cls = OWN_NEW;
        else if (owner == behind_own) cls = OWN_EMPTY;
        else                          cls = OWN_BAD;
    end
endmodule

// File: rtl/cq_payload_gather.sv
// Collects the payload words of one record as they return from memory.
// Assumes read data arrives exactly one cycle after each issued read.
module cq_payload_gather
    import cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_en,
    input  logic [WIDX_W-1:0] issue_idx,
    input  logic [WORD_W-1:0] rd_data,
    output logic [PAY_W-1:0]  payload
);
    logic              cap_q;
    logic [WIDX_W-1:0] cap_idx_q;

    // Delay the issue strobe to line up with returning data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_q     <= issue_en;
            cap_idx_q <= issue_idx;
        end
    end

    for (genvar i = 0; i < PAY_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        // Hold payload word i until the next record overwrites it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (cap_q && cap_idx_q == WIDX_W'(i))
                word_q <= rd_data;
        end
        assign payload[i*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/cq_doorbell_fmt.sv
// Builds and registers the armed doorbell word.
// Assumes the head given is final when fire is high.
module cq_doorbell_fmt
    import cq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [WQ_W-1:0]  queue_id,
    input  logic [PTR_W-1:0] head,
    output logic             db_valid,
    output logic [DB_W-1:0]  db_word
);
    // Register the doorbell one cycle after the fire request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_valid <= 1'b0;
            db_word  <= '0;
        end else begin
            db_valid <= fire;
            if (fire)
                db_word <= {1'b1, head, {DB_RSV_W{1'b0}}, queue_id};
        end
    end
endmodule

// File: rtl/cq_poll_ctrl.sv
// Poll sequencer: reads the control word at the head, fetches the payload
// of fresh records, emits them, and keeps the head and per-poll counters.
// Assumes a one-cycle memory read latency and no output back-pressure.
module cq_poll_ctrl
    import cq_pkg::*;
#(
    parameter int LOG2_ENTRIES = 4,
    parameter int CNT_W        = 6,
    localparam int ADDR_W      = LOG2_ENTRIES + WIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_req,
    input  logic [CNT_W-1:0]  poll_max,
    input  logic              poll_arm,
    input  owner_cls_e        cls,
    input  logic [WQ_W-1:0]   ctrl_wq,
    input  logic              ctrl_sq,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              issue_en,
    output logic [WIDX_W-1:0] issue_idx,
    output logic              cmp_valid,
    output logic [WQ_W-1:0]   cmp_wq_num,
    output logic              cmp_is_sq,
    output logic              poll_done,
    output logic [CNT_W-1:0]  poll_count,
    output logic              poll_overflow,
    output logic              db_fire,
    output logic [PTR_W-1:0]  head
);
    poll_state_e       state_q;
    logic [CNT_W-1:0]  max_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              arm_q;
    logic              ovf_q;
    logic [WIDX_W-1:0] word_q;
    logic [PTR_W-1:0]  head_q;
    logic [WQ_W-1:0]   wq_q;
    logic              sq_q;
    logic [LOG2_ENTRIES-1:0] slot;
    logic [CNT_W-1:0]  cnt_next;

    // Decode the current slot and the post-emit count.
    always_comb begin
        slot     = head_q[LOG2_ENTRIES-1:0];
        cnt_next = cnt_q + CNT_W'(1);
    end

    // Drive the memory read port from the state.
    always_comb begin
        mem_rd_en   = (state_q == ST_RD_CTRL) || (state_q == ST_RD_PAY);
        issue_en    = (state_q == ST_RD_PAY);
        issue_idx   = word_q;
        mem_rd_addr = {slot, (state_q == ST_RD_CTRL) ? WIDX_W'(CTRL_IDX) : word_q};
    end

    // Drive the completion, done and doorbell-request outputs.
    always_comb begin
        cmp_valid     = (state_q == ST_EMIT);
        cmp_wq_num    = wq_q;
        cmp_is_sq     = sq_q;
        poll_done     = (state_q == ST_DONE);
        poll_count    = cnt_q;
        poll_overflow = ovf_q;
        db_fire       = (state_q == ST_DONE) && arm_q;
        head          = head_q;
    end

    // Sequence a poll and keep the head, count and captured fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            max_q   <= '0;
            cnt_q   <= '0;
            arm_q   <= 1'b0;
            ovf_q   <= 1'b0;
            word_q  <= '0;
            head_q  <= '0;
            wq_q    <= '0;
            sq_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (poll_req) begin
                        max_q   <= poll_max;
                        arm_q   <= poll_arm;
                        cnt_q   <= '0;
                        ovf_q   <= 1'b0;
                        state_q <= (poll_max == '0) ? ST_DONE : ST_RD_CTRL;
                    end
                end
                ST_RD_CTRL: begin
                    state_q <= ST_WAIT_CTRL;
                end
                ST_WAIT_CTRL: begin
                    case (cls)
                        OWN_NEW: begin
                            wq_q    <= ctrl_wq;
                            sq_q    <= ctrl_sq;
                            word_q  <= '0;
                            state_q <= ST_RD_PAY;
                        end
                        OWN_EMPTY: state_q <= ST_DONE;
                        default: begin
                            ovf_q   <= 1'b1;
                            state_q <= ST_DONE;
                        end
                    endcase
                end
                ST_RD_PAY: begin
                    if (word_q == WIDX_W'(PAY_WORDS - 1))
                        state_q <= ST_PAY_LAST;
                    else
                        word_q <= word_q + WIDX_W'(1);
                end
                ST_PAY_LAST: begin
                    state_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    head_q  <= head_q + PTR_W'(1);
                    cnt_q   <= cnt_next;
                    state_q <= (cnt_next == max_q) ? ST_DONE : ST_RD_CTRL;
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cq_poller.sv
// Top of the completion ring poller: ties sequencer, owner classifier,
// payload collector and doorbell formatter together.
// Assumes the producer writes the owner field last in each record.
module cq_poller
    import cq_pkg::*;
#(
    parameter int LOG2_ENTRIES = 4,
    parameter int CNT_W        = 6,
    localparam int ADDR_W      = LOG2_ENTRIES + WIDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WQ_W-1:0]         cq_id,
    input  logic                    poll_req,
    input  logic [CNT_W-1:0]        poll_max,
    input  logic                    poll_arm,
    output logic                    poll_done,
    output logic [CNT_W-1:0]        poll_count,
    output logic                    poll_overflow,
    output logic                    mem_rd_en,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic [WORD_W-1:0]       mem_rd_data,
    output logic                    cmp_valid,
    output logic [WQ_W-1:0]         cmp_wq_num,
    output logic                    cmp_is_sq,
    output logic [PAY_W-1:0]        cmp_data,
    output logic                    db_valid,
    output logic [DB_W-1:0]         db_word
);
    owner_cls_e        cls;
    logic              issue_en;
    logic [WIDX_W-1:0] issue_idx;
    logic              db_fire;
    logic [PTR_W-1:0]  head_q;

    cq_owner_classify #(.LOG2_ENTRIES(LOG2_ENTRIES)) u_cls (
        .head  (head_q),
        .owner (mem_rd_data[WORD_W-1 -: OWNER_W]),
        .cls   (cls)
    );

    cq_poll_ctrl #(.LOG2_ENTRIES(LOG2_ENTRIES), .CNT_W(CNT_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .poll_req      (poll_req),
        .poll_max      (poll_max),
        .poll_arm      (poll_arm),
        .cls           (cls),
        .ctrl_wq       (mem_rd_data[WQ_W-1:0]),
        .ctrl_sq       (mem_rd_data[WQ_W]),
        .mem_rd_en     (mem_rd_en),
        .mem_rd_addr   (mem_rd_addr),
        .issue_en      (issue_en),
        .issue_idx     (issue_idx),
        .cmp_valid     (cmp_valid),
        .cmp_wq_num    (cmp_wq_num),
        .cmp_is_sq     (cmp_is_sq),
        .poll_done     (poll_done),
        .poll_count    (poll_count),
        .poll_overflow (poll_overflow),
        .db_fire       (db_fire),
        .head          (head_q)
    );

    cq_payload_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_en  (issue_en),
        .issue_idx (issue_idx),
        .rd_data   (mem_rd_data),
        .payload   (cmp_data)
    );

    cq_doorbell_fmt u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (db_fire),
        .queue_id (cq_id),
        .head     (head_q),
        .db_valid (db_valid),
        .db_word  (db_word)
    );
endmodule

// File: rtl/cq_poller_checker.sv
// Temporal checks on the poller's strobes, head and doorbell.
// Bound into every cq_poller instance.
module cq_poller_checker
    import cq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             poll_done,
    input logic             cmp_valid,
    input logic             db_valid,
    input logic [DB_W-1:0]  db_word,
    input logic [PTR_W-1:0] head_q
);
    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({poll_done, cmp_valid, db_valid}));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |=> !poll_done);

    assert_db_follows_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> $past(poll_done));

    assert_db_format_R9: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> (db_word[DB_W-1] && db_word[WQ_W +: DB_RSV_W] == '0
                      && db_word[WQ_W+DB_RSV_W +: PTR_W] == head_q));

    assert_head_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (head_q != $past(head_q)) |-> (head_q == $past(head_q) + PTR_W'(1)));

    assert_emit_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> (head_q == $past(head_q) + PTR_W'(1)));
endmodule

bind cq_poller cq_poller_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll_done (poll_done),
    .cmp_valid (cmp_valid),
    .db_valid  (db_valid),
    .db_word   (db_word),
    .head_q    (head_q)
);

// File: tb/tb_cq_poller.sv
module tb_cq_poller;
    localparam int L2 = 4;
    localparam int NE = 16;
    localparam int CW = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [23:0]  cq_id = 24'hABC123;
    logic         poll_req = 1'b0;
    logic [CW-1:0] poll_max = '0;
    logic         poll_arm = 1'b0;
    logic         poll_done, poll_overflow, mem_rd_en, cmp_valid, cmp_is_sq, db_valid;
    logic [CW-1:0] poll_count;
    logic [L2+3:0] mem_rd_addr;
    logic [31:0]  mem_rd_data;
    logic [23:0]  cmp_wq_num;
    logic [479:0] cmp_data;
    logic [63:0]  db_word;

    always #10 clk = ~clk;

    cq_poller #(.LOG2_ENTRIES(L2), .CNT_W(CW)) dut (.*);

    logic [31:0] mem [NE*16];
    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    int n_chk = 0, n_fail = 0;
    int cyc = 0, req_cyc = 0;
    int cmp_n = 0, done_n = 0, db_n = 0;
    int done_cyc = 0, db_cyc = 0;
    logic [CW-1:0] last_cnt;
    logic last_ovf;
    logic [63:0] last_db;
    logic [23:0] mon_wq [64];
    logic mon_sq [64];
    logic [479:0] mon_data [64];
    int mon_cyc [64];
    int head_m = 0;

    // Monitor on falling edges, plus watchdog.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (poll_req) req_cyc = cyc;
            if (cmp_valid && cmp_n < 64) begin
                mon_wq[cmp_n] = cmp_wq_num; mon_sq[cmp_n] = cmp_is_sq;
                mon_data[cmp_n] = cmp_data; mon_cyc[cmp_n] = cyc;
                cmp_n = cmp_n + 1;
            end
            if (poll_done) begin
                done_n = done_n + 1; done_cyc = cyc;
                last_cnt = poll_count; last_ovf = poll_overflow;
            end
            if (db_valid) begin db_n = db_n + 1; db_cyc = cyc; last_db = db_word; end
        end
        if (cyc > 100000) begin
            n_chk = n_chk + 1; n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pay_word(int slot, int own, int i);
        return 32'h1000_0000 + (slot << 16) + (own << 8) + i;
    endfunction

    task automatic put_entry(input int slot, input int own, input logic [3:0] rsv);
        logic [23:0] wq;
        wq = 24'h5A0000 + 24'(slot * 16 + own);
        for (int i = 0; i < 15; i++) mem[slot*16 + i] = pay_word(slot, own, i);
        mem[slot*16 + 15] = {3'(own), rsv, 1'(slot % 2), wq};
    endtask

    task automatic run_poll(input int mx, input bit arm, output int base_cmp, output int base_db);
        int base_done;
        base_cmp = cmp_n; base_db = db_n; base_done = done_n;
        @(negedge clk); #5;
        poll_req = 1'b1; poll_max = CW'(mx); poll_arm = arm;
        @(negedge clk); #5;
        poll_req = 1'b0;
        for (int w = 0; w < 3000 && done_n == base_done; w++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_emits(input int base, input int n, input string rq);
        for (int k = 0; k < n; k++) begin
            int slot;
            logic [479:0] expd;
            slot = (head_m + k) % NE;
            for (int i = 0; i < 15; i++) expd[i*32 +: 32] = mem[slot*16 + i];
            chk(mon_wq[base+k] == mem[slot*16+15][23:0], rq, "wq number",
                64'(mon_wq[base+k]), 64'(mem[slot*16+15][23:0]));
            chk(mon_sq[base+k] == mem[slot*16+15][24], rq, "send flag",
                64'(mon_sq[base+k]), 64'(mem[slot*16+15][24]));
            chk(mon_data[base+k] == expd, rq, "payload",
                mon_data[base+k][63:0], expd[63:0]);
        end
        head_m = head_m + n;
    endtask

    function automatic logic [63:0] exp_db(int h);
        return {1'b1, 31'(h), 8'h00, cq_id};
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!poll_done && !cmp_valid && !db_valid, "R1", "strobes idle in reset",
            64'({poll_done, cmp_valid, db_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!poll_done && !cmp_valid && !db_valid, "R1", "strobes idle after reset",
            64'({poll_done, cmp_valid, db_valid}), 64'd0);
    endtask

    task automatic t_empty();
        int bc, bd;
        run_poll(8, 1, bc, bd);
        chk(last_cnt == 0 && cmp_n == bc, "R4", "empty ring count", 64'(last_cnt), 64'd0);
        chk(done_cyc - req_cyc == 2, "R11", "empty done latency", 64'(done_cyc - req_cyc), 64'd2);
        chk(db_n == bd + 1 && db_cyc == done_cyc + 1, "R9", "doorbell one cycle after done",
            64'(db_cyc - done_cyc), 64'd1);
        chk(last_db == exp_db(0), "R1", "head zero after reset", last_db, exp_db(0));
    endtask

    task automatic t_basic();
        int bc, bd;
        for (int s = 0; s < 4; s++) put_entry(s, 0, (s == 2) ? 4'hF : 4'h0);
        run_poll(8, 0, bc, bd);
        chk(last_cnt == 4 && cmp_n == bc + 4, "R8", "count of four", 64'(last_cnt), 64'd4);
        chk(mon_cyc[bc] - req_cyc == 18, "R11", "first emit latency",
            64'(mon_cyc[bc] - req_cyc), 64'd18);
        chk(mon_cyc[bc+1] - mon_cyc[bc] == 19, "R11", "per-record spacing",
            64'(mon_cyc[bc+1] - mon_cyc[bc]), 64'd19);
        chk(db_n == bd, "R9", "no doorbell without arm", 64'(db_n - bd), 64'd0);
        chk(!last_ovf, "R3", "no overflow", 64'(last_ovf), 64'd0);
        check_emits(bc, 4, "R2/R3");
    endtask

    task automatic t_limit();
        int bc, bd;
        for (int s = 4; s < 16; s++) put_entry(s, 0, 4'h5);
        run_poll(2, 1, bc, bd);
        chk(last_cnt == 2, "R6", "limit of two", 64'(last_cnt), 64'd2);
        check_emits(bc, 2, "R6");
        chk(last_db == exp_db(head_m), "R9", "armed doorbell word", last_db, exp_db(head_m));
        run_poll(0, 1, bc, bd);
        chk(last_cnt == 0 && cmp_n == bc, "R6", "zero limit", 64'(cmp_n - bc), 64'd0);
        chk(last_db == exp_db(head_m), "R6", "zero limit keeps head", last_db, exp_db(head_m));
    endtask

    task automatic t_busy();
        int bc, bd, base_done;
        bc = cmp_n; base_done = done_n;
        @(negedge clk); #5;
        poll_req = 1'b1; poll_max = CW'(15); poll_arm = 1'b0;
        @(negedge clk); #5;
        poll_max = CW'(1); poll_arm = 1'b1;
        @(negedge clk); #5;
        poll_req = 1'b0;
        for (int w = 0; w < 3000 && done_n == base_done; w++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(done_n == base_done + 1, "R10", "one done for overlapped requests",
            64'(done_n - base_done), 64'd1);
        chk(last_cnt == 10, "R10", "first request's limit kept", 64'(last_cnt), 64'd10);
        check_emits(bc, 10, "R10");
    endtask

    task automatic t_wrap();
        int bc, bd;
        put_entry(0, 1, 4'h0);
        run_poll(4, 1, bc, bd);
        chk(last_cnt == 1, "R7", "second pass owner taken", 64'(last_cnt), 64'd1);
        check_emits(bc, 1, "R7");
        chk(last_db == exp_db(17), "R7", "head after wrap", last_db, exp_db(17));
    endtask

    task automatic t_overflow();
        int bc, bd;
        put_entry(1, 1, 4'h0);
        put_entry(2, 4, 4'h0);
        run_poll(8, 1, bc, bd);
        chk(last_cnt == 1 && last_ovf, "R5", "overflow after one",
            64'({last_ovf, last_cnt}), 64'({1'b1, 6'd1}));
        check_emits(bc, 1, "R5");
        run_poll(8, 1, bc, bd);
        chk(last_ovf && cmp_n == bc, "R5", "lapped record not emitted", 64'(cmp_n - bc), 64'd0);
        chk(last_db == exp_db(18), "R5", "head held on overflow", last_db, exp_db(18));
    endtask

    initial begin
        for (int a = 0; a < NE*16; a++) mem[a] = 32'hE000_0000;
        t_reset();
        t_empty();
        t_basic();
        t_limit();
        t_busy();
        t_wrap();
        t_overflow();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule